// File: doc/BRIEF.md
# Chained LFSR Test-Data Expander

This block is one stage of a linear test-data expander meant for a die in a vertical stack. On every shift cycle, a small group of compressed stimulus channels is XOR-ed into a 16-bit linear feedback shift register. The register keeps advancing through a fixed primitive feedback polynomial. A fixed XOR network reads register bits and drives the scan-chain inputs of the cores on the die. Each scan-cell value is therefore a linear combination of the injected channel bits.

A second XOR network produces a narrower set of upward taps. These taps become the channel inputs of the identical stage on the die above. Stages above the bottom layer are fed only from the layer below, and each layer up receives fewer channels. Because the stages are chained, every injected bit can still spread to every layer.

At the start of each test cube, a control pulse clears the register. This makes every cube an independent set of linear equations. The register advances only while scan shifting is enabled.

Top module: `lfsr_decomp_stage`

## Requirements
- R1: While reset (rstN low) is applied and after it is released, the register is zero, so scanOut and upOut are all zero until the first injection.
- R2: cubeStart high at a rising clock edge clears the register to zero, whatever shiftEn and chanIn are. scanOut and upOut read zero after that edge.
- R3: With shiftEn low and cubeStart low, the register holds its value, chanIn has no effect, and scanOut and upOut stay unchanged.
- R4: With shiftEn high and cubeStart low, each edge computes the next state as follows. First, the register shifts one place toward the high bit (bit i takes bit i-1). Bit 0 takes the feedback s[15]^s[13]^s[12]^s[10]. Then channel k (k=0..3) is XOR-ed into bit 4k.
- R5: scanOut[j] (j=0..7) equals s[j mod 16] ^ s[(j+5) mod 16] ^ s[(j+11) mod 16].
- R6: upOut[j] (j=0..1) equals s[(3j+1) mod 16] ^ s[(3j+7) mod 16] ^ s[(3j+12) mod 16]. There are fewer upward taps (2) than input channels (4).
- R7: Starting from a cleared register, the outputs are linear in the injected data. The outputs after a sequence A^B equal the XOR of the outputs after A and after B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cubeStart | input | 1 | Synchronous clear at a test-cube boundary |
| shiftEn | input | 1 | Advance the register by one step |
| chanIn | input | 4 | Compressed channels injected into the register |
| scanOut | output | 8 | Scan-chain inputs of this die's cores |
| upOut | output | 2 | Channels passed to the stage on the die above |

## Verification
Each channel is first pulsed on its own from a cleared register and then followed for twenty shifts. This separates the four injection points from one another and exposes the feedback polynomial once the pulse wraps around. Random channel streams are then compared cycle by cycle against an arithmetic model, which checks both XOR networks across many register states. Two further sequences are tried: a cleared-start superposition of two random sequences, which shows that the output is linear in the injected data; and hold cycles with active channels, and clears under active shifting, which show that the clear takes priority and that a held register ignores its inputs.

// File: rtl/decomp_pkg.sv
package decomp_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
  } stepCtrl_t;
endpackage

// File: rtl/decomp_ctrl.sv
module decomp_ctrl
  import decomp_pkg::*;
(
  input  logic      cubeStart,
  input  logic      shiftEn,
  output stepCtrl_t ctrl
);
  always_comb begin
    ctrl.clear   = cubeStart;
    ctrl.advance = shiftEn & ~cubeStart;
  end
endmodule

// File: rtl/decomp_lfsr.sv
module decomp_lfsr
  import decomp_pkg::*;
#(
  parameter int          LFSR_W   = 16,
  parameter int          IN_CH    = 4,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtrl_t         ctrl,
  input  logic [IN_CH-1:0]  chanIn,
  output logic [LFSR_W-1:0] state
);
  localparam int SPACING = LFSR_W / IN_CH;

  logic [LFSR_W-1:0] injectVec;
  logic [LFSR_W-1:0] shifted;
  logic              feedback;

  genvar k;
  generate
    for (k = 0; k < LFSR_W; k++) begin : g_inj
      if ((k % SPACING) == 0 && (k / SPACING) < IN_CH) begin : g_on
        assign injectVec[k] = chanIn[k / SPACING];
      end else begin : g_off
        assign injectVec[k] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    feedback = ^(state & TAP_MASK);
    shifted  = {state[LFSR_W-2:0], feedback};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= '0;
    end else if (ctrl.clear) begin
      state <= '0;
    end else if (ctrl.advance) begin
      state <= shifted ^ injectVec;
    end
  end
endmodule

// File: rtl/decomp_phase.sv
module decomp_phase #(
  parameter int LFSR_W = 16,
  parameter int OUT_N  = 8,
  parameter int STRIDE = 1,
  parameter int OFF0   = 0,
  parameter int OFF1   = 5,
  parameter int OFF2   = 11
) (
  input  logic [LFSR_W-1:0] state,
  output logic [OUT_N-1:0]  taps
);
  genvar j;
  generate
    for (j = 0; j < OUT_N; j++) begin : g_tap
      localparam int IDX_A = (STRIDE * j + OFF0) % LFSR_W;
      localparam int IDX_B = (STRIDE * j + OFF1) % LFSR_W;
      localparam int IDX_C = (STRIDE * j + OFF2) % LFSR_W;
      assign taps[j] = state[IDX_A] ^ state[IDX_B] ^ state[IDX_C];
    end
  endgenerate
endmodule

// File: rtl/lfsr_decomp_stage.sv
module lfsr_decomp_stage
  import decomp_pkg::*;
#(
  parameter int LFSR_W  = 16,
  parameter int IN_CH   = 4,
  parameter int SCAN_CH = 8,
  parameter int UP_CH   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cubeStart,
  input  logic               shiftEn,
  input  logic [IN_CH-1:0]   chanIn,
  output logic [SCAN_CH-1:0] scanOut,
  output logic [UP_CH-1:0]   upOut
);
  stepCtrl_t         ctrl;
  logic [LFSR_W-1:0] lfsrState;

  decomp_ctrl u_ctrl (
    .cubeStart(cubeStart),
    .shiftEn  (shiftEn),
    .ctrl     (ctrl)
  );

  decomp_lfsr #(.LFSR_W(LFSR_W), .IN_CH(IN_CH)) u_lfsr (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .chanIn(chanIn),
    .state (lfsrState)
  );

  decomp_phase #(.LFSR_W(LFSR_W), .OUT_N(SCAN_CH), .STRIDE(1),
                 .OFF0(0), .OFF1(5), .OFF2(11)) u_scanNet (
    .state(lfsrState),
    .taps (scanOut)
  );

  decomp_phase #(.LFSR_W(LFSR_W), .OUT_N(UP_CH), .STRIDE(3),
                 .OFF0(1), .OFF1(7), .OFF2(12)) u_upNet (
    .state(lfsrState),
    .taps (upOut)
  );
endmodule

// File: rtl/decomp_stage_checker.sv
module decomp_stage_checker #(
  parameter int LFSR_W  = 16,
  parameter int SCAN_CH = 8,
  parameter int UP_CH   = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               cubeStart,
  input logic               shiftEn,
  input logic [SCAN_CH-1:0] scanOut,
  input logic [UP_CH-1:0]   upOut,
  input logic [LFSR_W-1:0]  lfsrState
);
  p_reset_zero_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (scanOut == '0 && upOut == '0));

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    cubeStart |=> (lfsrState == '0 && scanOut == '0 && upOut == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cubeStart && !shiftEn) |=> ($stable(lfsrState) && $stable(scanOut) && $stable(upOut)));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !cubeStart) |=> (lfsrState[3:1] == $past(lfsrState[2:0])));
endmodule

bind lfsr_decomp_stage decomp_stage_checker #(
  .LFSR_W(LFSR_W), .SCAN_CH(SCAN_CH), .UP_CH(UP_CH)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cubeStart(cubeStart),
  .shiftEn  (shiftEn),
  .scanOut  (scanOut),
  .upOut    (upOut),
  .lfsrState(lfsrState)
);

// File: tb/lfsr_decomp_stage_bench.sv
module lfsr_decomp_stage_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cubeStart = 1'b0;
  logic       shiftEn = 1'b0;
  logic [3:0] chanIn = '0;
  logic [7:0] scanOut;
  logic [1:0] upOut;

  int total = 0;
  int bad = 0;
  logic [15:0] model = '0;

  always #2 clk = ~clk;

  lfsr_decomp_stage u_lfsr_decomp_stage (
    .clk(clk), .rstN(rstN), .cubeStart(cubeStart), .shiftEn(shiftEn),
    .chanIn(chanIn), .scanOut(scanOut), .upOut(upOut)
  );

  function automatic logic [15:0] nextOf(logic [15:0] s, logic [3:0] ch);
    logic [15:0] n;
    n = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    n[0]  = n[0]  ^ ch[0];
    n[4]  = n[4]  ^ ch[1];
    n[8]  = n[8]  ^ ch[2];
    n[12] = n[12] ^ ch[3];
    return n;
  endfunction

  function automatic logic [7:0] scanOf(logic [15:0] s);
    logic [7:0] o;
    for (int j = 0; j < 8; j++) o[j] = s[j % 16] ^ s[(j + 5) % 16] ^ s[(j + 11) % 16];
    return o;
  endfunction

  function automatic logic [1:0] upOf(logic [15:0] s);
    logic [1:0] o;
    for (int j = 0; j < 2; j++)
      o[j] = s[(3 * j + 1) % 16] ^ s[(3 * j + 7) % 16] ^ s[(3 * j + 12) % 16];
    return o;
  endfunction

  task automatic checkOut(string req);
    total++;
    if (scanOut !== scanOf(model) || upOut !== upOf(model)) begin
      bad++;
      $display("FAIL %s: scan=%h up=%h expected scan=%h up=%h",
               req, scanOut, upOut, scanOf(model), upOf(model));
    end
  endtask

  task automatic step(logic cs, logic se, logic [3:0] ch);
    @(negedge clk);
    cubeStart = cs; shiftEn = se; chanIn = ch;
    @(posedge clk);
    if (cs) model = '0;
    else if (se) model = nextOf(model, ch);
    #1;
  endtask

  logic [3:0] seqA [24];
  logic [3:0] seqB [24];
  logic [9:0] outA, outB, outAB;
  logic [9:0] holdSnap;
  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    total++;
    if (scanOut !== 8'h00 || upOut !== 2'b00) begin
      bad++; $display("FAIL R1: scan=%h up=%h expected 00 0", scanOut, upOut);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkOut("R1");

    // single-channel pulses: R4 injection points, R5/R6 networks
    for (int c = 0; c < 4; c++) begin
      step(1'b1, 1'b0, 4'h0);
      checkOut("R2");
      step(1'b0, 1'b1, 4'(1 << c));
      checkOut("R4");
      for (int t = 0; t < 20; t++) begin
        step(1'b0, 1'b1, 4'h0);
        checkOut("R4_R5_R6");
      end
    end

    // random streams with hold and clear interleaved
    step(1'b1, 1'b0, 4'h0);
    for (int t = 0; t < 300; t++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) begin
        step(1'b1, 1'b1, 4'($urandom));
        checkOut("R2 clear under shift");
        total++;
        if (scanOut !== 8'h00 || upOut !== 2'b00) begin
          bad++; $display("FAIL R2: scan=%h up=%h expected 00 0", scanOut, upOut);
        end
      end else if (r < 4) begin
        holdSnap = {scanOut, upOut};
        step(1'b0, 1'b0, 4'($urandom));
        total++;
        if ({scanOut, upOut} !== holdSnap) begin
          bad++; $display("FAIL R3: out=%h expected %h", {scanOut, upOut}, holdSnap);
        end
      end else begin
        step(1'b0, 1'b1, 4'($urandom));
        checkOut("R5_R6 random");
      end
    end

    // superposition
    for (int t = 0; t < 24; t++) begin
      seqA[t] = 4'($urandom);
      seqB[t] = 4'($urandom);
    end
    step(1'b1, 1'b0, 4'h0);
    for (int t = 0; t < 24; t++) step(1'b0, 1'b1, seqA[t]);
    outA = {scanOut, upOut};
    step(1'b1, 1'b0, 4'h0);
    for (int t = 0; t < 24; t++) step(1'b0, 1'b1, seqB[t]);
    outB = {scanOut, upOut};
    step(1'b1, 1'b0, 4'h0);
    for (int t = 0; t < 24; t++) step(1'b0, 1'b1, seqA[t] ^ seqB[t]);
    outAB = {scanOut, upOut};
    total++;
    if (outAB !== (outA ^ outB)) begin
      bad++; $display("FAIL R7: out=%h expected %h", outAB, outA ^ outB);
    end
    checkOut("R7 model");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule